// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter placed beside a bank of event sources. Each source group carries several sub-event lines that pulse once per cycle when something happens. Software programs a 32-bit configuration word that picks one group by its event code and a unit mask that picks sub-event lines inside that group. Each cycle the block counts how many of the picked lines are high.

That per-cycle count is then qualified. With a zero threshold the counter simply adds the count. With a nonzero threshold the cycle becomes a single yes/no condition: the count reaches the threshold, or with invert set, stays below it. An optional rising-edge filter turns a run of true cycles into one increment. The 48-bit counter can be read at any time and preloaded by software.

Top module: `evt_qual_counter`

## Requirements
- R1: The configuration word is stored on `cfg_wr` and read back on `cfg_rdata` from the next cycle. Its layout is: bits [7:0] event code, [15:8] unit mask, bit 16 edge filter, bit 17 invert, bit 18 counter enable, [31:24] threshold. Bits [23:19] always read as zero. Reset clears the word to zero.
- R2: Event code g (g below NUM_GROUPS) selects the lines `evt_lines[g*8 +: 8]`. Unit mask bit i enables line i of that group. Several mask bits count the union of their lines, so the per-cycle count is the number of lines that are both high and enabled.
- R3: An event code of NUM_GROUPS or more, or a unit mask of zero, gives a per-cycle count of zero, and the counter does not move.
- R4: With a threshold of zero, the counter adds the full per-cycle count each enabled cycle. The invert and edge bits have no effect in this mode.
- R5: With a nonzero threshold and invert clear, the counter adds exactly one in each cycle whose count is greater than or equal to the threshold, and adds nothing otherwise.
- R6: With a nonzero threshold and invert set, the counter adds one in each cycle whose count is strictly below the threshold.
- R7: With a nonzero threshold and the edge bit set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle.
- R8: The previous-condition history reads as false after a configuration write or after any cycle with the enable bit clear. A condition that is true in the first counted cycle after either of these is therefore counted.
- R9: `cnt_rdata` shows the counter, which resets to zero. `cnt_wr` loads `cnt_wdata` on the next edge, and this load wins over an increment in the same cycle.
- R10: With the enable bit clear, the counter holds its value whatever the event lines do.
- R11: The counter is 48 bits wide and wraps to zero modulo 2^48 without any other effect.
- R12: In a cycle with `cfg_wr` high, no increment is made under either the old or the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_lines | input | NUM_GROUPS*SUB_W (32) | Per-cycle sub-event lines, one SUB_W-bit slice per event code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| cnt_wr | input | 1 | Counter preload strobe |
| cnt_wdata | input | CNT_W (48) | Counter preload value |
| cnt_rdata | output | CNT_W (48) | Current counter value |

## Verification
The bench targets the threshold boundary, where the count equals the threshold exactly. A design that uses the wrong comparison would miss those cycles in normal mode, or count them in invert mode. Runs of true conditions in edge mode check that the history register is kept and cleared at the right moments. A design that gets this wrong either counts every true cycle or misses the first one after a reprogram or re-enable. It also checks that a preload beats a same-cycle increment, that the 48-bit counter wraps cleanly from all ones, that a configuration-write cycle does not count, and that unknown codes and empty masks count nothing. Long random runs mix all modes with thresholds above the group width.

// File: rtl/evt_qual_pkg.sv
package evt_qual_pkg;

  localparam int CFG_W = 32;

  // Configuration word layout; fields are decoded by the counter logic.
  typedef struct packed {
    logic [7:0] thr;
    logic [4:0] rsvd;
    logic       en;
    logic       inv;
    logic       edge_en;
    logic [7:0] umask;
    logic [7:0] sel;
  } evq_cfg_t;

  // Bits that are kept on a configuration write; reserved bits read zero.
  localparam logic [CFG_W-1:0] CFG_KEEP = 32'hFF07_FFFF;

endpackage

// File: rtl/evt_select.sv
module evt_select #(
  parameter int NUM_GROUPS = 4,
  parameter int SUB_W      = 8,
  localparam int LINES_W   = NUM_GROUPS * SUB_W,
  localparam int POP_W     = $clog2(SUB_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES_W-1:0] evt_lines,
  input  logic [7:0]         sel,
  input  logic [7:0]         umask,
  output logic [POP_W-1:0]   pop
);

  logic [NUM_GROUPS-1:0] grp_hit;
  logic [SUB_W-1:0]      grp_lines;
  logic [SUB_W-1:0]      masked;

  // One code comparator per source group.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_decode
    assign grp_hit[g] = (sel == 8'(g));
  end

  always_comb begin
    grp_lines = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) grp_lines = evt_lines[g*SUB_W +: SUB_W];
    end
  end

  assign masked = grp_lines & umask[SUB_W-1:0];

  always_comb begin
    pop = '0;
    for (int i = 0; i < SUB_W; i++) begin
      pop = pop + POP_W'(masked[i]);
    end
  end

  // R3: an empty mask or an unknown code yields no events
  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (umask[SUB_W-1:0] == '0) |-> (pop == '0));
  assert_unknown_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel) >= NUM_GROUPS) |-> (pop == '0));

endmodule

// File: rtl/evt_qualify.sv
module evt_qualify #(
  parameter int POP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POP_W-1:0] pop,
  input  logic [7:0]       thr,
  input  logic             inv,
  input  logic             edge_en,
  input  logic             en,
  input  logic             clr,
  output logic [POP_W-1:0] inc
);

  logic [7:0] pop8;
  logic       reach;
  logic       hit;
  logic       prev_q;
  logic       prev_d;

  assign pop8  = 8'(pop);
  assign reach = (pop8 >= thr);
  assign hit   = (thr != 8'd0) && (inv ? !reach : reach);

  always_comb begin
    if (!en) begin
      inc = '0;
    end else if (thr == 8'd0) begin
      inc = pop;
    end else if (edge_en) begin
      inc = POP_W'(hit && !prev_q);
    end else begin
      inc = POP_W'(hit);
    end
  end

  // History of the qualified condition; forced false on reprogram or disable.
  always_comb begin
    prev_d = (en && !clr) ? hit : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R5: a thresholded cycle adds at most one
  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != 8'd0) |-> (inc <= POP_W'(1)));
  // R7: in edge mode two back-to-back increments cannot happen
  assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_en && (thr != 8'd0) && !clr && (inc != '0)) |=> (inc == '0));
  // R10: nothing is produced while disabled
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (inc == '0));

endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
  parameter int CNT_W = 48,
  parameter int POP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             en,
  input  logic [POP_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_ce = wr || en;

  always_comb begin
    if (wr) cnt_d = wdata;
    else    cnt_d = cnt + CNT_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end

  // R9: preload wins over any increment
  assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)));
  // R10: held while not counting
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !en) |=> $stable(cnt));
  // R11: modular accumulation
  assert_wrap_add_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && en) |=> (cnt == $past(cnt) + CNT_W'($past(inc))));

endmodule

// File: rtl/evt_qual_counter.sv
module evt_qual_counter
  import evt_qual_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int SUB_W      = 8,
  parameter int CNT_W      = 48,
  localparam int LINES_W   = NUM_GROUPS * SUB_W,
  localparam int POP_W     = $clog2(SUB_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES_W-1:0] evt_lines,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  output logic [CNT_W-1:0]   cnt_rdata
);

  logic       rst_meta;
  logic       rst_sync_n;
  evq_cfg_t   cfg_q;
  evq_cfg_t   cfg_d;
  logic [POP_W-1:0] pop;
  logic [POP_W-1:0] inc;
  logic             acc_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    cfg_d = evq_cfg_t'(cfg_wdata & CFG_KEEP);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= '0;
    else if (cfg_wr)  cfg_q <= cfg_d;
  end

  assign cfg_rdata = cfg_q;

  evt_select #(
    .NUM_GROUPS (NUM_GROUPS),
    .SUB_W      (SUB_W)
  ) u_select (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_lines (evt_lines),
    .sel       (cfg_q.sel),
    .umask     (cfg_q.umask),
    .pop       (pop)
  );

  evt_qualify #(
    .POP_W (POP_W)
  ) u_qualify (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pop     (pop),
    .thr     (cfg_q.thr),
    .inv     (cfg_q.inv),
    .edge_en (cfg_q.edge_en),
    .en      (cfg_q.en),
    .clr     (cfg_wr),
    .inc     (inc)
  );

  // A configuration-write cycle is blanked from counting.
  assign acc_en = cfg_q.en && !cfg_wr;

  evt_accum #(
    .CNT_W (CNT_W),
    .POP_W (POP_W)
  ) u_accum (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (cnt_wr),
    .wdata (cnt_wdata),
    .en    (acc_en),
    .inc   (inc),
    .cnt   (cnt_rdata)
  );

  // R1: stored word matches the written word with reserved bits cleared
  assert_cfg_read_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & CFG_KEEP)));
  // R12: no count in a configuration-write cycle
  assert_cfg_blank_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_wr && !cnt_wr) |=> (cnt_rdata == $past(cnt_rdata)));

endmodule

// File: tb/test_evt_qual_counter.sv
`timescale 1ns/1ps
module test_evt_qual_counter;

  localparam int NG = 4;
  localparam int SW = 8;
  localparam int CW = 48;
  localparam logic [31:0] KEEP = 32'hFF07_FFFF;

  logic          clk;
  logic          rst_n;
  logic [31:0]   evt_lines;
  logic          cfg_wr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          cnt_wr;
  logic [CW-1:0] cnt_wdata;
  logic [CW-1:0] cnt_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0]   cfg_m;
  logic          prev_m;
  logic [CW-1:0] cnt_m;

  evt_qual_counter i_evt_qual_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_lines (evt_lines),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt_rdata (cnt_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mkcfg(int sel, int umask, int thr,
                                        bit edg, bit inv, bit en);
    return {8'(thr), 5'b0, en, inv, edg, 8'(umask), 8'(sel)};
  endfunction

  function automatic int m_pop(logic [31:0] lines, logic [31:0] c);
    int s;
    logic [7:0] g;
    s = int'(c[7:0]);
    if (s >= NG) return 0;
    g = lines[s*8 +: 8];
    return $countones(g & c[15:8]);
  endfunction

  function automatic bit m_hit(int pop, logic [31:0] c);
    int thr;
    bit ge;
    thr = int'(c[31:24]);
    if (thr == 0) return 1'b0;
    ge = (pop >= thr);
    return c[17] ? !ge : ge;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model, check after the
  // next rising edge.
  task automatic step(logic [31:0] lines, bit do_cfg, logic [31:0] cw,
                      bit do_cnt, logic [CW-1:0] nw, string req);
    int pop, inc;
    bit hit;
    evt_lines = lines;
    cfg_wr    = do_cfg;
    cfg_wdata = cw;
    cnt_wr    = do_cnt;
    cnt_wdata = nw;
    pop = m_pop(lines, cfg_m);
    hit = m_hit(pop, cfg_m);
    if (!cfg_m[18])               inc = 0;
    else if (cfg_m[31:24] == 8'd0) inc = pop;
    else if (cfg_m[16])            inc = (hit && !prev_m) ? 1 : 0;
    else                           inc = hit ? 1 : 0;
    if (do_cnt)                    cnt_m = nw;
    else if (cfg_m[18] && !do_cfg) cnt_m = cnt_m + CW'(inc);
    prev_m = (cfg_m[18] && !do_cfg) ? hit : 1'b0;
    if (do_cfg) cfg_m = cw & KEEP;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    cnt_wr = 1'b0;
    check(req, 64'(cnt_rdata), 64'(cnt_m));
    if (do_cfg) check("R1", 64'(cfg_rdata), 64'(cfg_m));
  endtask

  task automatic ev(logic [31:0] lines, string req);
    step(lines, 1'b0, 32'h0, 1'b0, '0, req);
  endtask

  task automatic cfg(logic [31:0] cw, string req);
    step(32'h0, 1'b1, cw, 1'b0, '0, req);
  endtask

  task automatic load(logic [CW-1:0] v, string req);
    step(32'h0, 1'b0, 32'h0, 1'b1, v, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; evt_lines = '0; cfg_wr = 1'b0; cfg_wdata = '0;
    cnt_wr = 1'b0; cnt_wdata = '0;
    cfg_m = '0; prev_m = 1'b0; cnt_m = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 / R1: reset state
    check("R9", 64'(cnt_rdata), 64'h0);
    check("R1", 64'(cfg_rdata), 64'h0);

    // R1: reserved bits drop on write; enable clear so nothing counts
    cfg(32'hFFFB_FFFF, "R1");
    ev(32'hFFFF_FFFF, "R10");

    // R4: zero threshold adds popcount, edge and invert ignored
    cfg(mkcfg(1, 8'h0F, 0, 1, 1, 1), "R12");
    ev(32'h0000_FF00, "R4");
    ev(32'h0000_FF00, "R4");
    ev(32'h0000_0500, "R4");
    ev(32'hFFFF_00FF, "R4");

    // R2: union of two mask bits, group 2
    cfg(mkcfg(2, 8'h03, 0, 0, 0, 1), "R12");
    ev(32'h0001_0000, "R2");
    ev(32'h0003_0000, "R2");
    ev(32'h00FC_0000, "R2");

    // R3: unknown code and empty mask
    cfg(mkcfg(9, 8'hFF, 0, 0, 0, 1), "R12");
    ev(32'hFFFF_FFFF, "R3");
    cfg(mkcfg(0, 8'h00, 1, 0, 0, 1), "R12");
    ev(32'hFFFF_FFFF, "R3");

    // R5: threshold 3, boundary at exactly 3
    cfg(mkcfg(0, 8'hFF, 3, 0, 0, 1), "R12");
    ev(32'h0000_0003, "R5");
    ev(32'h0000_0007, "R5");
    ev(32'h0000_001F, "R5");

    // R6: invert, count below 3
    cfg(mkcfg(0, 8'hFF, 3, 0, 1, 1), "R12");
    ev(32'h0000_0003, "R6");
    ev(32'h0000_0007, "R6");
    ev(32'h0000_0000, "R6");

    // R7: edge mode, run of true cycles counts once
    cfg(mkcfg(3, 8'h80, 1, 1, 0, 1), "R12");
    ev(32'h8000_0000, "R7");
    ev(32'h8000_0000, "R7");
    ev(32'h8000_0000, "R7");
    ev(32'h0000_0000, "R7");
    ev(32'h8000_0000, "R7");

    // R8: history cleared by reprogramming and by disable
    cfg(mkcfg(3, 8'h80, 1, 1, 0, 1), "R8");
    ev(32'h8000_0000, "R8");
    cfg(mkcfg(3, 8'h80, 1, 1, 0, 0), "R8");
    ev(32'h8000_0000, "R10");
    cfg(mkcfg(3, 8'h80, 1, 1, 0, 1), "R8");
    ev(32'h8000_0000, "R8");

    // R12: configuration write with events present does not count
    cfg(mkcfg(0, 8'hFF, 0, 0, 0, 1), "R12");
    step(32'h0000_00FF, 1'b1, mkcfg(0, 8'hFF, 0, 0, 0, 1), 1'b0, '0, "R12");

    // R9: preload beats increment
    step(32'h0000_00FF, 1'b0, 32'h0, 1'b1, 48'h1234_5678_9ABC, "R9");
    ev(32'h0000_0001, "R9");

    // R11: wrap through all ones
    load({CW{1'b1}} - 48'd1, "R9");
    ev(32'h0000_000F, "R11");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ln, cw;
      logic [CW-1:0] nw;
      bit dc, dn;
      ln = $urandom;
      dc = ($urandom % 12) == 0;
      dn = ($urandom % 40) == 0;
      cw = mkcfg($urandom % 6, ($urandom % 5 == 0) ? 0 : $urandom % 256,
                 ($urandom % 3 == 0) ? 0 : $urandom % 10,
                 $urandom % 2, $urandom % 2, ($urandom % 8) != 0);
      nw = ($urandom % 2) ? ({CW{1'b1}} - CW'($urandom % 16))
                          : {16'($urandom), 32'($urandom)};
      step(ln, dc, cw, dn, nw, "R2 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule